// File: doc/BRIEF.md
# Operator Phase Increment and Rate Calculator

This unit serves one FM operator per request. From the channel pitch (a 10-bit frequency number and a 3-bit octave field) and the operator's 4-bit frequency multiplier code, it forms the per-sample phase increment. The unit also derives the following values for the envelope timing logic:

- the channel key code;
- the operator's key-scale rate offset;
- for each of the attack, decay and release fields: the effective rate, the counter shift and the step-pattern selector.

A sequencer that walks the operators presents one request per cycle with `req_valid` high. The results appear on the outputs one cycle later, qualified by `rsp_valid`. The outputs keep their last values until the next request arrives. The block is fully pipelined, so back-to-back requests are accepted every cycle.

Top module: `op_rate_calc`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. All outputs reflect the inputs of that request.
- R2: While `req_valid` is low, every result output holds its previous value, whatever the other inputs do.
- R3: Multiplier codes 0 to 15 select the factors 1, 2, 4, 6, 8, 10, 12, 14, 16, 18, 20, 20, 24, 24, 30, 30.
- R4: `phase_inc` equals (fnum × factor × 4) shifted right by (7 − octave). It is 20 bits wide and is never truncated.
- R5: `key_code[3:1]` equals the octave field.
- R6: `key_code[0]` is `fnum[8]` when `note_sel` is 1 and `fnum[9]` when `note_sel` is 0.
- R7: `ks_offset` is `key_code` when `ksr_full` is 1, and `key_code` >> 2 when `ksr_full` is 0.
- R8: A rate code C maps to a base of 16 + 4C when C is nonzero, and to 0 when C is 0. Each `*_rate` output is that base plus `ks_offset`.
- R9: For an effective rate E, the shift is 0 when E < 16, 12 − (E − 16)/4 when 16 ≤ E ≤ 63, and 0 when E ≥ 64.
- R10: The selector is 112 when E < 16, (E mod 4) × 8 when 16 ≤ E ≤ 67, 32 + 8 × (E − 68) when 68 ≤ E ≤ 75, and 96 when E ≥ 76.
- R11: When the effective attack rate is 76 or more, `atk_instant` is 1, the attack shift is 0 and the attack selector is 104. Decay and release never take this path.
- R12: After a synchronous reset with `rst_n` low, `rsp_valid` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| fnum | input | 10 | Channel frequency number |
| octave | input | 3 | Channel octave (block) field |
| mult_code | input | 4 | Operator multiplier code |
| ksr_full | input | 1 | 1: full key code is rate offset; 0: key code >> 2 |
| note_sel | input | 1 | Global note-select flag for key code bit 0 |
| atk_code | input | 4 | Attack rate code |
| dec_code | input | 4 | Decay rate code |
| rel_code | input | 4 | Release rate code |
| rsp_valid | output | 1 | Results valid |
| phase_inc | output | 20 | Phase increment per sample |
| key_code | output | 4 | Channel key code |
| ks_offset | output | 4 | Key-scale rate offset |
| atk_rate | output | 7 | Effective attack rate |
| atk_shift | output | 4 | Attack counter shift |
| atk_sel | output | 7 | Attack step-pattern selector |
| atk_instant | output | 1 | Attack completes at once |
| dec_rate | output | 7 | Effective decay rate |
| dec_shift | output | 4 | Decay counter shift |
| dec_sel | output | 7 | Decay step-pattern selector |
| rel_rate | output | 7 | Effective release rate |
| rel_shift | output | 4 | Release counter shift |
| rel_sel | output | 7 | Release step-pattern selector |

## Verification
The bound checker watches several properties on every cycle:

- the one-cycle response strobe;
- holding of results between requests;
- the octave bits of the key code;
- the offset never exceeding the key code;
- a zero code yielding a rate equal to the offset;
- the reserved-rate and instantaneous-attack encodings.

The exact increment arithmetic, the nonlinear multiplier table, the note-select bit choice and the full shift and selector curves are shown only by the bench's sweeps. These sweeps cover every octave, multiplier code, rate code, both note-select settings and both key-scale modes.

// File: rtl/op_rate_pkg.sv
// Shared widths, result type and multiplier table for the operator rate calculator.
// Assumes 4-bit multiplier codes; factors are in half-units.
package op_rate_pkg;
    localparam int KC_W    = 4;
    localparam int RATE_W  = 7;
    localparam int SHIFT_W = 4;
    localparam int SEL_W   = 7;
    localparam int FACT_W  = 5;

    typedef struct packed {
        logic [RATE_W-1:0]  eff;
        logic [SHIFT_W-1:0] shift;
        logic [SEL_W-1:0]   sel;
        logic               instant;
    } rate_res_t;

    // Map a multiplier code to its (nonlinear) factor.
    function automatic logic [FACT_W-1:0] mult_factor(input logic [3:0] code);
        case (code)
            4'd0:  return 5'd1;
            4'd1:  return 5'd2;
            4'd2:  return 5'd4;
            4'd3:  return 5'd6;
            4'd4:  return 5'd8;
            4'd5:  return 5'd10;
            4'd6:  return 5'd12;
            4'd7:  return 5'd14;
            4'd8:  return 5'd16;
            4'd9:  return 5'd18;
            4'd10: return 5'd20;
            4'd11: return 5'd20;
            4'd12: return 5'd24;
            4'd13: return 5'd24;
            default: return 5'd30;
        endcase
    endfunction
endpackage

// File: rtl/op_inc_calc.sv
// Phase increment: (fnum * factor * 4) >> (max_octave - octave).
// Assumes INC_W holds the unshifted product without loss.
module op_inc_calc #(
    parameter int FNUM_W = 10,
    parameter int OCT_W  = 3,
    parameter int MUL_W  = 4,
    parameter int INC_W  = 20
) (
    input  logic [FNUM_W-1:0] fnum,
    input  logic [OCT_W-1:0]  octave,
    input  logic [MUL_W-1:0]  mult_code,
    output logic [INC_W-1:0]  phase_inc
);
    localparam int PROD_W = FNUM_W + op_rate_pkg::FACT_W + 2;

    logic [PROD_W-1:0] scaled;
    logic [OCT_W-1:0]  rshift;

    // Scale the frequency number and shift down by the octave distance from the top.
    always_comb begin
        scaled    = PROD_W'(fnum * op_rate_pkg::mult_factor(4'(mult_code))) << 2;
        rshift    = ~octave;
        phase_inc = INC_W'(scaled >> rshift);
    end
endmodule

// File: rtl/op_keycode.sv
// Key code from octave and one frequency bit chosen by note_sel; key-scale offset from it.
// Assumes FNUM_W >= 2.
module op_keycode #(
    parameter int FNUM_W = 10,
    parameter int OCT_W  = 3
) (
    input  logic [FNUM_W-1:0]         fnum,
    input  logic [OCT_W-1:0]          octave,
    input  logic                      note_sel,
    input  logic                      ksr_full,
    output logic [OCT_W:0]            key_code,
    output logic [OCT_W:0]            ks_offset
);
    // Build the key code and scale it according to the operator's mode bit.
    always_comb begin
        key_code  = {octave, note_sel ? fnum[FNUM_W-2] : fnum[FNUM_W-1]};
        ks_offset = ksr_full ? key_code : (key_code >> 2);
    end
endmodule

// File: rtl/op_rate_map.sv
// Maps a 4-bit rate code plus key-scale offset to effective rate, shift and selector.
// IS_ATTACK enables the instantaneous path for the top of the attack range.
module op_rate_map #(
    parameter int CODE_W    = 4,
    parameter int KS_W      = 4,
    parameter bit IS_ATTACK = 1'b0
) (
    input  logic [CODE_W-1:0]     code,
    input  logic [KS_W-1:0]       ks,
    output op_rate_pkg::rate_res_t res
);
    import op_rate_pkg::*;

    localparam int RESV_TOP   = 16;   // below: reserved rates
    localparam int SHIFT_END  = 64;   // at and above: shift 0
    localparam int CYCLE_END  = 68;   // end of the repeating select pattern
    localparam int RAMP_END   = 76;   // end of the rising select ramp
    localparam int INST_RATE  = 76;   // attack at or above: instantaneous
    localparam int SEL_RESV   = 112;
    localparam int SEL_TOP    = 96;
    localparam int SEL_RAMP0  = 32;
    localparam int SEL_INST   = 104;
    localparam int TOP_SHIFT  = 12;

    logic [RATE_W-1:0] base;
    logic [RATE_W-1:0] eff;

    // Compute the effective rate.
    always_comb begin
        base = (code == '0) ? '0 : RATE_W'(RESV_TOP + 4 * int'(code));
        eff  = base + RATE_W'(ks);
    end

    // Shift and selector curves, with optional instantaneous attack override.
    always_comb begin
        res.eff     = eff;
        res.instant = 1'b0;
        if (eff < RATE_W'(RESV_TOP))
            res.shift = '0;
        else if (eff < RATE_W'(SHIFT_END))
            res.shift = SHIFT_W'(TOP_SHIFT - int'((eff - RATE_W'(RESV_TOP)) >> 2));
        else
            res.shift = '0;

        if (eff < RATE_W'(RESV_TOP))
            res.sel = SEL_W'(SEL_RESV);
        else if (eff < RATE_W'(CYCLE_END))
            res.sel = {2'b00, eff[1:0], 3'b000};
        else if (eff < RATE_W'(RAMP_END))
            res.sel = SEL_W'(SEL_RAMP0 + 8 * int'(eff - RATE_W'(CYCLE_END)));
        else
            res.sel = SEL_W'(SEL_TOP);

        if (IS_ATTACK && eff >= RATE_W'(INST_RATE)) begin
            res.instant = 1'b1;
            res.shift   = '0;
            res.sel     = SEL_W'(SEL_INST);
        end
    end
endmodule

// File: rtl/op_rate_calc.sv
// Top: per-operator phase increment, key code, key-scale offset and envelope rates.
// Results register one cycle after req_valid and hold until the next request.
module op_rate_calc #(
    parameter int FNUM_W = 10,
    parameter int OCT_W  = 3,
    parameter int MUL_W  = 4,
    parameter int CODE_W = 4,
    parameter int INC_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [FNUM_W-1:0] fnum,
    input  logic [OCT_W-1:0]  octave,
    input  logic [MUL_W-1:0]  mult_code,
    input  logic              ksr_full,
    input  logic              note_sel,
    input  logic [CODE_W-1:0] atk_code,
    input  logic [CODE_W-1:0] dec_code,
    input  logic [CODE_W-1:0] rel_code,
    output logic              rsp_valid,
    output logic [INC_W-1:0]  phase_inc,
    output logic [OCT_W:0]    key_code,
    output logic [OCT_W:0]    ks_offset,
    output logic [6:0]        atk_rate,
    output logic [3:0]        atk_shift,
    output logic [6:0]        atk_sel,
    output logic              atk_instant,
    output logic [6:0]        dec_rate,
    output logic [3:0]        dec_shift,
    output logic [6:0]        dec_sel,
    output logic [6:0]        rel_rate,
    output logic [3:0]        rel_shift,
    output logic [6:0]        rel_sel
);
    import op_rate_pkg::*;

    localparam int KCW   = OCT_W + 1;
    localparam int NRATE = 3;

    logic [INC_W-1:0]  inc_c;
    logic [KCW-1:0]    kc_c;
    logic [KCW-1:0]    ks_c;
    logic [CODE_W-1:0] codes [NRATE];
    rate_res_t         res_c [NRATE];
    rate_res_t         res_q [NRATE];

    op_inc_calc #(.FNUM_W(FNUM_W), .OCT_W(OCT_W), .MUL_W(MUL_W), .INC_W(INC_W)) u_inc (
        .fnum(fnum), .octave(octave), .mult_code(mult_code), .phase_inc(inc_c)
    );

    op_keycode #(.FNUM_W(FNUM_W), .OCT_W(OCT_W)) u_kc (
        .fnum(fnum), .octave(octave), .note_sel(note_sel), .ksr_full(ksr_full),
        .key_code(kc_c), .ks_offset(ks_c)
    );

    assign codes[0] = atk_code;
    assign codes[1] = dec_code;
    assign codes[2] = rel_code;

    // One rate mapper per envelope phase; index 0 is the attack variant.
    for (genvar g = 0; g < NRATE; g++) begin : g_rate
        op_rate_map #(.CODE_W(CODE_W), .KS_W(KCW), .IS_ATTACK(g == 0)) u_map (
            .code(codes[g]), .ks(ks_c), .res(res_c[g])
        );
    end

    // Capture results on a request; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            phase_inc <= '0;
            key_code  <= '0;
            ks_offset <= '0;
            for (int i = 0; i < NRATE; i++) res_q[i] <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                phase_inc <= inc_c;
                key_code  <= kc_c;
                ks_offset <= ks_c;
                for (int i = 0; i < NRATE; i++) res_q[i] <= res_c[i];
            end
        end
    end

    assign atk_rate    = res_q[0].eff;
    assign atk_shift   = res_q[0].shift;
    assign atk_sel     = res_q[0].sel;
    assign atk_instant = res_q[0].instant;
    assign dec_rate    = res_q[1].eff;
    assign dec_shift   = res_q[1].shift;
    assign dec_sel     = res_q[1].sel;
    assign rel_rate    = res_q[2].eff;
    assign rel_shift   = res_q[2].shift;
    assign rel_sel     = res_q[2].sel;
endmodule

// File: rtl/op_rate_calc_chk.sv
// Checker for op_rate_calc: temporal properties on its ports, attached by bind.
module op_rate_calc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [2:0]  octave,
    input logic [3:0]  atk_code,
    input logic [3:0]  dec_code,
    input logic        rsp_valid,
    input logic [19:0] phase_inc,
    input logic [3:0]  key_code,
    input logic [3:0]  ks_offset,
    input logic [6:0]  atk_shift,
    input logic [6:0]  atk_sel,
    input logic        atk_instant,
    input logic [6:0]  dec_rate,
    input logic [6:0]  rel_rate,
    input logic [3:0]  rel_shift,
    input logic [6:0]  rel_sel
);
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(phase_inc) && $stable(key_code) && $stable(dec_rate)));
    assert_octave_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> key_code[3:1] == $past(octave));
    assert_offset_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ks_offset <= key_code);
    assert_zero_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dec_code == 4'd0) |=> dec_rate == 7'(ks_offset));
    assert_reserved_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rel_rate < 7'd16) |-> (rel_sel == 7'd112 && rel_shift == 4'd0));
    assert_instant_attack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && atk_code == 4'd15) |=> (atk_instant && atk_sel == 7'd104));
endmodule

bind op_rate_calc op_rate_calc_chk i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .octave(octave),
    .atk_code(atk_code), .dec_code(dec_code), .rsp_valid(rsp_valid),
    .phase_inc(phase_inc), .key_code(key_code), .ks_offset(ks_offset),
    .atk_shift(7'(atk_shift)), .atk_sel(atk_sel), .atk_instant(atk_instant),
    .dec_rate(dec_rate), .rel_rate(rel_rate), .rel_shift(rel_shift), .rel_sel(rel_sel)
);

// File: tb/test_op_rate_calc.sv
// Sweep bench for op_rate_calc; expected values computed from the requirements.
module test_op_rate_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [9:0]  fnum = '0;
    logic [2:0]  octave = '0;
    logic [3:0]  mult_code = '0;
    logic        ksr_full = 1'b0;
    logic        note_sel = 1'b0;
    logic [3:0]  atk_code = '0, dec_code = '0, rel_code = '0;
    logic        rsp_valid;
    logic [19:0] phase_inc;
    logic [3:0]  key_code, ks_offset;
    logic [6:0]  atk_rate, atk_sel, dec_rate, dec_sel, rel_rate, rel_sel;
    logic [3:0]  atk_shift, dec_shift, rel_shift;
    logic        atk_instant;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    op_rate_calc i_op_rate_calc (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fact(input int c);
        case (c)
            0: return 1;  1: return 2;  2: return 4;  3: return 6;
            4: return 8;  5: return 10; 6: return 12; 7: return 14;
            8: return 16; 9: return 18; 10: return 20; 11: return 20;
            12: return 24; 13: return 24; default: return 30;
        endcase
    endfunction

    function automatic int e_shift(input int e);
        if (e < 16) return 0;
        if (e < 64) return 12 - (e - 16) / 4;
        return 0;
    endfunction

    function automatic int e_sel(input int e);
        if (e < 16) return 112;
        if (e < 68) return (e % 4) * 8;
        if (e < 76) return 32 + 8 * (e - 68);
        return 96;
    endfunction

    function automatic int e_rate(input int c, input int ks);
        return ((c == 0) ? 0 : 16 + 4 * c) + ks;
    endfunction

    // Check one registered response against the stimulus that produced it.
    task automatic check_vec(input int f, input int b, input int m, input int ns, input int kf,
                             input int a, input int d, input int r);
        int kc, ks, ea, ed, er, inc;
        inc = ((f * fact(m)) * 4) >> (7 - b);
        kc  = b * 2 + (ns ? ((f >> 8) & 1) : ((f >> 9) & 1));
        ks  = kf ? kc : kc >> 2;
        ea  = e_rate(a, ks);
        ed  = e_rate(d, ks);
        er  = e_rate(r, ks);
        chk(rsp_valid == 1'b1, "R1 rsp_valid", rsp_valid, 1);
        chk(phase_inc == inc, "R3/R4 phase_inc", phase_inc, inc);
        chk(key_code[3:1] == b, "R5 key_code octave", key_code[3:1], b);
        chk(key_code[0] == kc[0], "R6 key_code lsb", key_code[0], kc & 1);
        chk(ks_offset == ks, "R7 ks_offset", ks_offset, ks);
        chk(atk_rate == ea && dec_rate == ed && rel_rate == er, "R8 rates", dec_rate, ed);
        chk(dec_shift == e_shift(ed) && rel_shift == e_shift(er), "R9 shift", dec_shift, e_shift(ed));
        chk(dec_sel == e_sel(ed) && rel_sel == e_sel(er), "R10 sel", dec_sel, e_sel(ed));
        if (ea >= 76) begin
            chk(atk_instant && atk_shift == 0 && atk_sel == 104, "R11 instant attack", atk_sel, 104);
        end else begin
            chk(!atk_instant && atk_shift == e_shift(ea) && atk_sel == e_sel(ea),
                "R9/R10 attack curve", atk_sel, e_sel(ea));
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int flist [6] = '{0, 1023, 256, 512, 341, 682};
        int lf, lb, lm, lns, lkf, la, ld, lr;
        bit have = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(rsp_valid == 0 && phase_inc == 0 && key_code == 0 && ks_offset == 0 &&
            atk_rate == 0 && atk_sel == 0 && rel_sel == 0 && !atk_instant,
            "R12 reset state", phase_inc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Pipelined sweep: one request per cycle, check previous at each negedge.
        for (int fi = 0; fi < 6; fi++)
            for (int b = 0; b < 8; b++)
                for (int m = 0; m < 16; m++)
                    for (int ns = 0; ns < 2; ns++)
                        for (int kf = 0; kf < 2; kf++) begin
                            if (have) check_vec(lf, lb, lm, lns, lkf, la, ld, lr);
                            lf = flist[fi]; lb = b; lm = m; lns = ns; lkf = kf;
                            la = m; ld = 15 - m; lr = (m + b) % 16;
                            fnum = 10'(lf); octave = 3'(lb); mult_code = 4'(lm);
                            note_sel = 1'(lns); ksr_full = 1'(lkf);
                            atk_code = 4'(la); dec_code = 4'(ld); rel_code = 4'(lr);
                            req_valid = 1'b1;
                            have = 1'b1;
                            @(negedge clk);
                        end
        check_vec(lf, lb, lm, lns, lkf, la, ld, lr);
        req_valid = 1'b0;
        // R2: inputs change while idle; outputs must hold the last result
        fnum = 10'd77; octave = 3'd1; mult_code = 4'd0; atk_code = 4'd0;
        dec_code = 4'd0; rel_code = 4'd0; note_sel = 1'b0; ksr_full = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 no response when idle", rsp_valid, 0);
        @(negedge clk);
        chk(phase_inc == (((lf * fact(lm)) * 4) >> (7 - lb)), "R2 hold phase_inc",
            phase_inc, ((lf * fact(lm)) * 4) >> (7 - lb));
        chk(key_code[3:1] == lb && rel_rate != 0, "R2 hold key_code", key_code[3:1], lb);
        // Maximum increment corner: R4 no truncation
        fnum = 10'd1023; octave = 3'd7; mult_code = 4'd15; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(phase_inc == 20'd122760, "R4 max increment", phase_inc, 122760);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule